// File: doc/BRIEF.md
# Write Gate and Trim Erase Controller

This block sits on the drive side of a floppy-style write path. It takes an active-low write gate, a media write-protect sense and the write-data pulse stream. From these it drives the write-current enable, the read-path disable, the trim-erase enable, a step-inhibit level and a gated copy of the write data. When the protect sense is high, every write-side output is held low, whatever the gate does. When a write ends, trim erase stays on for a hold interval, and stepping stays blocked for a longer settling interval. A sticky flag reports a first data pulse that lands outside the allowed window after the gate's leading edge.

All intervals are counted in clock cycles. Each is a parameter in microseconds, multiplied by `CYC_PER_US`. The defaults are a 550 µs trim hold, a 1000 µs settle and a 2 to 4 µs first-pulse window. A four-state machine sequences the block:
- `ST_IDLE` is the rest state.
- `ST_WRITE` is entered on the edge that samples the gate low. This transition is named *gate_on* and can be taken from any state.
- `ST_TRIM` is entered on the edge that samples the gate high while writing (*release*).
- `ST_SETTLE` is entered when the trim hold count is reached (*trim_done*).
- The block returns to `ST_IDLE` when the settle count is reached (*settle_done*).

Inputs are assumed to be synchronous to `clk`.

Top module: `write_gate_ctrl`

## Requirements
- R1: On the clock edge that samples `wgate_n` low, the block enters the write state, and from the next cycle `wr_cur_en` and `rd_dis` are high, provided `wprot` is low. On the edge that samples `wgate_n` high, the write state ends and both outputs fall.
- R2: While `wprot` is high, `wr_cur_en`, `rd_dis`, `trim_en` and `wdata_drv` are low in that same cycle, whatever the state of `wgate_n`.
- R3: `trim_en` is high throughout the write state. After the write state ends, it stays high for exactly TRIM_CYC = TRIM_US*CYC_PER_US further cycles and then goes low. This holds while `wprot` is low.
- R4: `step_inh` is high in every cycle that follows a clock edge sampling `wgate_n` low.
- R5: After the write state ends, `step_inh` stays high for exactly SETTLE_CYC = SETTLE_US*CYC_PER_US cycles and then goes low. It is low in the idle state.
- R6: If `wgate_n` is sampled low during the trim hold or the settle period, the block returns to the write state and `trim_en` does not drop. Both the trim hold and the settle interval then restart from the next release.
- R7: `wdata_drv` equals `wdata` in cycles where `wr_cur_en` is high, and is low otherwise.
- R8: Write-state cycles are numbered from index 0, the first cycle after the gate is sampled low. If the first cycle with `wdata` high lands at an index below WIN_MIN_CYC or above WIN_MAX_CYC, `tviol` goes high in the following cycle. A first pulse whose index falls inside that range leaves `tviol` low.
- R9: `tviol` stays high until the next entry into the write state clears it. Later pulses within the same write are not evaluated.
- R10: While `rst_n` is low, and directly after it, the block is in the idle state and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wgate_n | input | 1 | Write gate, active low |
| wprot | input | 1 | Write-protected media sensed, active high |
| wdata | input | 1 | Write data pulse, one cycle per pulse |
| wr_cur_en | output | 1 | Write current enable |
| rd_dis | output | 1 | Read electronics disable |
| trim_en | output | 1 | Trim erase enable |
| step_inh | output | 1 | Step inhibit |
| wdata_drv | output | 1 | Write data passed to the write driver |
| tviol | output | 1 | Sticky first-pulse timing violation flag |

## Verification
The gate is driven in four patterns, each compared against a behavioural model on every cycle:
- A clean write with a first pulse inside the window confirms that the window bounds do not fire falsely.
- An early first pulse followed by a later in-window pulse shows that the flag is sticky and that only the first pulse is judged.
- Reasserting the gate partway through the trim hold separates a restarted timer from one that keeps running from the first release.
- A protected write with a late pulse shows that protection silences the write outputs while stepping and flag logic still follow the gate.

A final fresh write confirms that the flag clears on entry.

// File: rtl/wgc_pkg.sv
package wgc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRITE  = 2'd1,
        ST_TRIM   = 2'd2,
        ST_SETTLE = 2'd3
    } wgc_state_e;
endpackage

// File: rtl/wgc_seq.sv
module wgc_seq
    import wgc_pkg::*;
#(
    parameter int TRIM_CYC   = 55000,
    parameter int SETTLE_CYC = 100000,
    parameter int CNT_W      = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_on,
    output wgc_state_e       state_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX    = '1;
    localparam logic [CNT_W-1:0] TRIM_LAST  = CNT_W'(TRIM_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

    wgc_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // transitions: gate_on, release, trim_done, settle_done
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (gate_on) begin
                    state_nx = ST_WRITE;
                    cnt_nx   = '0;
                end
            end
            ST_WRITE: begin
                if (!gate_on) begin
                    state_nx = ST_TRIM;
                    cnt_nx   = '0;
                end else if (cnt != CNT_MAX) begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            ST_TRIM: begin
                if (gate_on) begin
                    state_nx = ST_WRITE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                    if (cnt == TRIM_LAST) state_nx = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (gate_on) begin
                    state_nx = ST_WRITE;
                    cnt_nx   = '0;
                end else if (cnt == SETTLE_LAST) begin
                    state_nx = ST_IDLE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
        endcase
    end

    assign state_o = state;
    assign cnt_o   = cnt;
endmodule

// File: rtl/wgc_lead_mon.sv
module wgc_lead_mon #(
    parameter int WIN_MIN_CYC = 200,
    parameter int WIN_MAX_CYC = 400,
    parameter int CNT_W       = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             in_write,
    input  logic             wdata,
    input  logic [CNT_W-1:0] cnt,
    output logic             viol_o
);
    localparam logic [CNT_W-1:0] LO = CNT_W'(WIN_MIN_CYC);
    localparam logic [CNT_W-1:0] HI = CNT_W'(WIN_MAX_CYC);

    logic viol, seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            viol <= 1'b0;
            seen <= 1'b0;
        end else if (start) begin
            viol <= 1'b0;
            seen <= 1'b0;
        end else if (in_write && wdata && !seen) begin
            seen <= 1'b1;
            if (cnt < LO || cnt > HI) viol <= 1'b1;
        end
    end

    assign viol_o = viol;
endmodule

// File: rtl/write_gate_ctrl.sv
module write_gate_ctrl
    import wgc_pkg::*;
#(
    parameter int CYC_PER_US = 100,
    parameter int TRIM_US    = 550,
    parameter int SETTLE_US  = 1000,
    parameter int WIN_MIN_US = 2,
    parameter int WIN_MAX_US = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wgate_n,
    input  logic wprot,
    input  logic wdata,
    output logic wr_cur_en,
    output logic rd_dis,
    output logic trim_en,
    output logic step_inh,
    output logic wdata_drv,
    output logic tviol
);
    localparam int TRIM_CYC    = TRIM_US * CYC_PER_US;
    localparam int SETTLE_CYC  = SETTLE_US * CYC_PER_US;
    localparam int WIN_MIN_CYC = WIN_MIN_US * CYC_PER_US;
    localparam int WIN_MAX_CYC = WIN_MAX_US * CYC_PER_US;
    localparam int CNT_W       = $clog2(SETTLE_CYC + 1);

    wgc_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             gate_on, in_write;

    assign gate_on  = !wgate_n;
    assign in_write = (state == ST_WRITE);

    wgc_seq #(
        .TRIM_CYC  (TRIM_CYC),
        .SETTLE_CYC(SETTLE_CYC),
        .CNT_W     (CNT_W)
    ) seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .gate_on(gate_on),
        .state_o(state),
        .cnt_o  (cnt)
    );

    wgc_lead_mon #(
        .WIN_MIN_CYC(WIN_MIN_CYC),
        .WIN_MAX_CYC(WIN_MAX_CYC),
        .CNT_W      (CNT_W)
    ) lead_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (gate_on && !in_write),
        .in_write(in_write),
        .wdata   (wdata),
        .cnt     (cnt),
        .viol_o  (tviol)
    );

    // outputs
    always_comb begin
        wr_cur_en = 1'b0;
        trim_en   = 1'b0;
        step_inh  = 1'b1;
        unique case (state)
            ST_IDLE:   step_inh = 1'b0;
            ST_WRITE: begin
                wr_cur_en = !wprot;
                trim_en   = !wprot;
            end
            ST_TRIM:   trim_en = !wprot;
            ST_SETTLE: trim_en = 1'b0;
        endcase
        rd_dis    = wr_cur_en;
        wdata_drv = wdata && wr_cur_en;
    end
endmodule

// File: rtl/wgc_checker.sv
module wgc_checker #(
    parameter int TRIM_CYC   = 55000,
    parameter int SETTLE_CYC = 100000
) (
    input logic clk,
    input logic rst_n,
    input logic wgate_n,
    input logic wprot,
    input logic wr_cur_en,
    input logic rd_dis,
    input logic trim_en,
    input logic step_inh,
    input logic wdata_drv,
    input logic tviol,
    input logic in_write
);
    logic [31:0] run;
    logic        had_write;

    // cycles since the gate was last sampled low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run       <= '0;
            had_write <= 1'b0;
        end else if (!wgate_n) begin
            run       <= '0;
            had_write <= 1'b1;
        end else if (run != 32'hFFFF_FFFF) begin
            run <= run + 1;
        end
    end

    AST_PROT_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        wprot |-> (!wr_cur_en && !rd_dis && !trim_en && !wdata_drv)); // R2
    AST_GATE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (!wgate_n && !wprot) |=> (wr_cur_en || wprot)); // R1
    AST_GATE_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
        !wgate_n |=> step_inh); // R4
    AST_TRIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (had_write && !wprot && run <= 32'(TRIM_CYC)) |-> trim_en); // R3
    AST_TRIM_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run > 32'(TRIM_CYC)) |-> !trim_en); // R3
    AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (had_write && run <= 32'(SETTLE_CYC)) |-> step_inh); // R5
    AST_SETTLE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run > 32'(SETTLE_CYC)) |-> !step_inh); // R5
    AST_DRV_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        wdata_drv |-> $past(!wgate_n)); // R7
    AST_FLAG_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_write) |-> !tviol); // R9
endmodule

bind write_gate_ctrl wgc_checker #(
    .TRIM_CYC  (TRIM_CYC),
    .SETTLE_CYC(SETTLE_CYC)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wgate_n  (wgate_n),
    .wprot    (wprot),
    .wr_cur_en(wr_cur_en),
    .rd_dis   (rd_dis),
    .trim_en  (trim_en),
    .step_inh (step_inh),
    .wdata_drv(wdata_drv),
    .tviol    (tviol),
    .in_write (in_write)
);

// File: tb/write_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module write_gate_ctrl_tb_top;
    localparam int CPU     = 2;
    localparam int TRIM    = 550 * CPU;
    localparam int SETTLE  = 1000 * CPU;
    localparam int WMIN    = 2 * CPU;
    localparam int WMAX    = 4 * CPU;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gate_n = 1'b1;
    logic prot = 1'b0;
    logic wd = 1'b0;
    logic wr_cur_en, rd_dis, trim_en, step_inh, wdata_drv, tviol;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    write_gate_ctrl #(.CYC_PER_US(CPU)) dut_i (
        .clk(clk), .rst_n(rst_n), .wgate_n(gate_n), .wprot(prot), .wdata(wd),
        .wr_cur_en(wr_cur_en), .rd_dis(rd_dis), .trim_en(trim_en),
        .step_inh(step_inh), .wdata_drv(wdata_drv), .tviol(tviol)
    );

    // behavioural reference
    bit m_write, m_had, m_viol, m_first;
    int m_rel, m_wcnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_write = 0; m_had = 0; m_viol = 0; m_first = 0; m_rel = 0; m_wcnt = 0;
        end else begin
            if (m_write && wd && !m_first) begin
                m_first = 1;
                if (m_wcnt < WMIN || m_wcnt > WMAX) m_viol = 1;
            end
            if (!gate_n) begin
                if (!m_write) begin m_viol = 0; m_first = 0; m_wcnt = 0; end
                else m_wcnt++;
                m_write = 1; m_had = 1; m_rel = 0;
            end else if (m_write) begin
                m_write = 0; m_rel = 1;
            end else if (m_rel < 1000000) begin
                m_rel++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit e_wr, e_trim, e_step;
            e_wr   = m_write && !prot;
            e_trim = !prot && (m_write || (m_had && m_rel <= TRIM));
            e_step = m_write || (m_had && m_rel <= SETTLE);
            chk(wr_cur_en == e_wr, "R1 wr_cur_en", wr_cur_en, e_wr);
            chk(rd_dis == e_wr, "R1 rd_dis", rd_dis, e_wr);
            chk(trim_en == e_trim, "R3 trim_en", trim_en, e_trim);
            chk(step_inh == e_step, "R5 step_inh", step_inh, e_step);
            chk(wdata_drv == (wd && e_wr), "R7 wdata_drv", wdata_drv, wd && e_wr);
            chk(tviol == m_viol, "R8 tviol", tviol, m_viol);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // gate low, one pulse at write index k, gate high after len cycles
    task automatic burst(input int k, input int len);
        gate_n = 1'b0;
        tick(k + 1);
        wd = 1'b1;
        @(negedge clk);
        chk(step_inh == 1'b1, "R4 gate inhibits step", step_inh, 1);
        if (!prot) chk(wdata_drv == 1'b1, "R7 pulse passed", wdata_drv, 1);
        tick(1);
        wd = 1'b0;
        tick(len - k - 1);
        gate_n = 1'b1;
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                if (!done) begin
                    total++; fails++;
                    $display("FAIL watchdog expired");
                    done = 1'b1;
                    $display("%0d/%0d checks passed", total - fails, total);
                    $finish;
                end
            end
        join_none
    end

    initial begin
        tick(3);
        @(negedge clk);
        chk({wr_cur_en, rd_dis, trim_en, step_inh, wdata_drv, tviol} == 6'b0,
            "R10 reset outputs", {wr_cur_en, rd_dis, trim_en, step_inh, wdata_drv, tviol}, 0);
        rst_n = 1'b1;
        tick(4);

        // clean write, pulse inside window
        burst(5, 20);
        @(negedge clk);
        chk(tviol == 1'b0, "R8 in-window pulse", tviol, 0);
        tick(SETTLE + 50);
        chk(step_inh == 1'b0, "R5 step released", step_inh, 0);

        // early first pulse, then a valid one
        gate_n = 1'b0;
        tick(2);
        @(negedge clk);
        chk(wr_cur_en == 1'b1, "R1 write enabled", wr_cur_en, 1);
        wd = 1'b1; tick(1); wd = 1'b0;
        tick(5);
        wd = 1'b1; tick(1); wd = 1'b0;
        tick(5);
        @(negedge clk);
        chk(tviol == 1'b1, "R9 flag sticky", tviol, 1);
        gate_n = 1'b1;
        tick(500);
        gate_n = 1'b0;
        tick(10);
        gate_n = 1'b1;
        tick(1050);
        @(negedge clk);
        chk(trim_en == 1'b1, "R6 trim restarted", trim_en, 1);
        tick(SETTLE);

        // protected write with a late pulse
        prot = 1'b1;
        burst(12, 30);
        @(negedge clk);
        chk(wr_cur_en == 1'b0 && trim_en == 1'b0, "R2 protect silences", wr_cur_en, 0);
        chk(tviol == 1'b1, "R8 late pulse flagged", tviol, 1);
        tick(SETTLE + 20);
        prot = 1'b0;

        // fresh write clears the flag
        gate_n = 1'b0;
        tick(2);
        @(negedge clk);
        chk(tviol == 1'b0, "R9 flag cleared on entry", tviol, 0);
        gate_n = 1'b1;
        tick(SETTLE + 20);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule